// File: doc/BRIEF.md
# Dual-Phase Coarse Delay Counter

This block is a coarse digital-to-time converter. It places a single rising edge, `th_reached_o`, a programmed number of fast-clock periods after a timing reference, so that a fine interpolator further down the path can add sub-period delay. Internally the fast clock is split into two half-rate phases, phase-0 and phase-180, by a two-bit rotating ring. The phases fall on alternate fast edges. The first fast edge after reset release is a phase-0 edge.

The upper `CODE_W-1` bits of the count advance only on phase-0 edges. Each phase-0 edge compares them with the upper part of the requested code. The phase-180 stage then adds the last half step. It asserts the output one fast period after a phase-0 match, but only when the code's least significant bit is 1. The output is the OR of the two per-phase results. The timing reference is always a phase-0 edge, where the upper count is cleared. A start pulse that arrives on a phase-180 edge is held for one edge and launches on the next phase-0 edge. The step is one fast period and the full scale is `2^CODE_W` steps.

Top module: `dual_phase_delay_ctr`

## Requirements
- R1: While reset is held, and afterwards until the first accepted start, `th_reached_o` and `busy_o` are 0.
- R2: A start sampled on a phase-0 edge (an even edge, counting the first edge after reset release as edge 0) is the reference. `th_reached_o` rises exactly `code` fast edges after that edge. A code of 0 raises it on the start edge itself.
- R3: A start sampled on a phase-180 edge (an odd edge) uses the next phase-0 edge as its reference. `th_reached_o` then rises `code + 1` edges after the start edge.
- R4: For an even code the rising edge of `th_reached_o` falls on a phase-0 edge. For an odd code it falls on a phase-180 edge.
- R5: `th_reached_o` stays high until the next accepted start. It is cleared on the edge that accepts that start, unless the new code is 0 and the start is on a phase-0 edge.
- R6: `busy_o` is high from the edge that accepts a start until the edge on which `th_reached_o` rises, and falls on that edge.
- R7: A start pulse that arrives while `busy_o` is high is ignored. It changes neither the rise time nor the code in use.
- R8: Every code from 0 to `2^CODE_W-1` is reached, without wrap of the upper count.
- R9: The code is captured on the edge that accepts a start. Later changes on `code_i` have no effect on the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock; its period is one delay step |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled on every fast edge |
| code_i | input | CODE_W | Requested delay in fast periods |
| th_reached_o | output | 1 | Rises when the requested delay has elapsed |
| busy_o | output | 1 | A run is pending or counting |

## Verification
The rising edge of `th_reached_o` is due `code` edges after a start on a phase-0 edge, or `code + 1` edges after a start on a phase-180 edge. The bench numbers every fast edge from reset release, so it knows the phase of each start. It drives inputs and samples outputs only on falling edges, and takes the first falling edge with the output high as the rise. `busy_o` is checked on every sample between the start and the rise: it must be high before the rise and low from the rise onward. The bench sweeps all 64 codes at both start phases. It then adds random runs in which a second start is injected, or `code_i` is changed, while the run is in flight.

// File: rtl/dpd_pkg.sv
package dpd_pkg;
  // one-hot phase ring state: bit0 = phase-0, bit1 = phase-180
  typedef enum logic [1:0] {
    PH0   = 2'b01,
    PH180 = 2'b10
  } phase_e;
endpackage

// File: rtl/dpd_phase_ring.sv
module dpd_phase_ring
  import dpd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  output logic ph0_o,
  output logic ph180_o
);
  logic [1:0] ring_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ring_q <= PH0;
    else         ring_q <= {ring_q[0], ring_q[1]};
  end

  assign ph0_o   = ring_q[0];
  assign ph180_o = ring_q[1];

  p_phase_alt_a_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph0_o |=> ph180_o && !ph0_o);
  p_phase_alt_b_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph180_o |=> ph0_o && !ph180_o);
endmodule

// File: rtl/dpd_hi_stage.sv
module dpd_hi_stage #(
  parameter int unsigned HI_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ph0_i,
  input  logic            launch_i,
  input  logic            clr_i,
  input  logic [HI_W-1:0] code_hi_i,
  input  logic            lsb_i,
  output logic            match_o,
  output logic            th0_o
);
  localparam logic [HI_W-1:0] ONE = HI_W'(1);

  logic [HI_W-1:0] hi_q, hi_nxt;
  logic            cnt_en_q, match_q, th0_q, hit;

  always_comb begin
    hi_nxt = launch_i ? '0 : hi_q + ONE;
    hit    = (launch_i | cnt_en_q) && (hi_nxt == code_hi_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q     <= '0;
      cnt_en_q <= 1'b0;
      match_q  <= 1'b0;
      th0_q    <= 1'b0;
    end else if (ph0_i) begin
      if (launch_i | cnt_en_q) hi_q <= hi_nxt;
      cnt_en_q <= (launch_i | cnt_en_q) & ~hit;
      match_q  <= hit;
      th0_q    <= (launch_i ? 1'b0 : th0_q) | (hit & ~lsb_i);
    end else if (clr_i) begin
      th0_q <= 1'b0;
    end
  end

  assign match_o = match_q;
  assign th0_o   = th0_q;

  // upper count never sits at its top value while still counting
  p_no_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_en_q |-> hi_q != '1);
  // counting only advances on phase-0 edges
  p_hi_ph0_only_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ph0_i |=> $stable(hi_q));
endmodule

// File: rtl/dpd_lo_stage.sv
module dpd_lo_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ph180_i,
  input  logic clr_i,
  input  logic match_i,
  input  logic lsb_i,
  output logic th1_o
);
  logic th1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          th1_q <= 1'b0;
    else if (clr_i)                       th1_q <= 1'b0;
    else if (ph180_i && match_i && lsb_i) th1_q <= 1'b1;
  end

  assign th1_o = th1_q;

  // odd codes finish on a phase-180 edge
  p_lo_on_ph180_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(th1_q) |-> $past(ph180_i) && $past(match_i));
endmodule

// File: rtl/dual_phase_delay_ctr.sv
module dual_phase_delay_ctr #(
  parameter int unsigned CODE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              th_reached_o,
  output logic              busy_o
);
  localparam int unsigned HI_W = CODE_W - 1;

  logic              ph0, ph180;
  logic              accept, launch;
  logic              pend_q, run_q;
  logic [CODE_W-1:0] code_q, code_eff;
  logic              match, th0, th1;

  dpd_phase_ring u_ring (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ph0_o  (ph0),
    .ph180_o(ph180)
  );

  assign busy_o       = pend_q | (run_q & ~th_reached_o);
  assign accept       = start_i & ~busy_o;
  assign launch       = ph0 & (pend_q | accept);
  assign code_eff     = accept ? code_i : code_q;
  assign th_reached_o = th0 | th1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      pend_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      if (accept) code_q <= code_i;
      if (ph180 && accept) pend_q <= 1'b1;
      else if (launch)     pend_q <= 1'b0;
      if (launch)            run_q <= 1'b1;
      else if (th_reached_o) run_q <= 1'b0;
    end
  end

  dpd_hi_stage #(.HI_W(HI_W)) u_hi (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ph0_i    (ph0),
    .launch_i (launch),
    .clr_i    (accept),
    .code_hi_i(code_eff[CODE_W-1:1]),
    .lsb_i    (code_eff[0]),
    .match_o  (match),
    .th0_o    (th0)
  );

  dpd_lo_stage u_lo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ph180_i(ph180),
    .clr_i  (accept),
    .match_i(match),
    .lsb_i  (code_q[0]),
    .th1_o  (th1)
  );

  p_ignore_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(code_q));
  p_th_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (th_reached_o && !accept) |=> th_reached_o);
  p_busy_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(th_reached_o) |-> !busy_o);
  p_pend_one_edge_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |=> !pend_q && run_q);
endmodule

// File: tb/dual_phase_delay_ctr_test.sv
`timescale 1ns/1ps
module dual_phase_delay_ctr_test;
  localparam int unsigned CW = 6;
  localparam int unsigned NCODE = 1 << CW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [CW-1:0] code_i = '0;
  logic          th_reached_o, busy_o;

  int unsigned cyc = 0;
  int          n_run = 0;
  int          n_fail = 0;

  always #2.5 clk_i = ~clk_i;
  always @(posedge clk_i) if (rst_ni) cyc <= cyc + 1;

  dual_phase_delay_ctr #(.CODE_W(CW)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .code_i(code_i),
    .th_reached_o(th_reached_o), .busy_o(busy_o)
  );

  function automatic int exp_delay(int c, bit odd_start);
    return c + (odd_start ? 1 : 0);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_one(int c, bit odd_start, bit inject, bit wiggle);
    int s, rise;
    bit found, busy_bad;
    while ((cyc % 2) != (odd_start ? 1 : 0)) @(negedge clk_i);
    start_i = 1'b1;
    code_i  = CW'(c);
    s = int'(cyc);
    @(negedge clk_i);
    start_i = 1'b0;
    if (wiggle) code_i = CW'($urandom);  // R9
    // R5: cleared at accept unless immediate finish
    if (!(c == 0 && !odd_start))
      chk(th_reached_o == 1'b0, "R5 clear", int'(th_reached_o), 0);
    found = 1'b0; busy_bad = 1'b0; rise = 0;
    for (int k = 0; k < 300 && !found; k++) begin
      start_i = 1'b0;
      if (th_reached_o) begin
        found = 1'b1;
        rise  = int'(cyc) - 1;
      end else begin
        if (!busy_o) busy_bad = 1'b1;
        if (inject && k == 1) begin  // R7
          start_i = 1'b1;
          code_i  = ~CW'(c);
        end
        if (wiggle) code_i = CW'($urandom);
        @(negedge clk_i);
      end
    end
    start_i = 1'b0;
    chk(found, "R8 reached", int'(found), 1);
    chk(rise - s == exp_delay(c, odd_start), odd_start ? "R3 delay" : "R2 delay",
        rise - s, exp_delay(c, odd_start));
    chk((rise % 2) == (c % 2), "R4 phase", rise % 2, c % 2);
    chk(!busy_bad, "R6 busy high", int'(busy_bad), 0);
    chk(busy_o == 1'b0, "R6 busy drop", int'(busy_o), 0);
    if (inject) chk(rise - s == exp_delay(c, odd_start), "R7 ignored",
                    rise - s, exp_delay(c, odd_start));
    repeat (3) @(negedge clk_i);
    chk(th_reached_o == 1'b1, "R5 hold", int'(th_reached_o), 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    chk(th_reached_o == 1'b0 && busy_o == 1'b0, "R1 in reset",
        {th_reached_o, busy_o}, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk(th_reached_o == 1'b0 && busy_o == 1'b0, "R1 idle",
        {th_reached_o, busy_o}, 0);
    // directed corners
    run_one(0, 1'b0, 1'b0, 1'b0);
    run_one(0, 1'b1, 1'b0, 1'b0);
    run_one(1, 1'b0, 1'b0, 1'b0);
    run_one(NCODE - 1, 1'b1, 1'b1, 1'b1);
    // full sweep at both phases
    for (int c = 0; c < NCODE; c++) begin
      run_one(c, 1'b0, 1'b0, 1'b0);
      run_one(c, 1'b1, 1'b0, 1'b0);
    end
    // random runs with injected starts and code changes (R7, R9)
    for (int i = 0; i < 60; i++)
      run_one(int'($urandom % NCODE), 1'($urandom), 1'($urandom), 1'b1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule